// File: doc/BRIEF.md
# Parity-Protected Byte RAM

This block is a synchronous single-port byte memory in which every location holds a ninth bit next to its eight data bits. The extra bit is computed from the write data and stored with it. When a read is tagged as a data access, the block checks the stored word. A failed check sets a sticky error flag. If the reset mask bit is clear, it also raises a one-cycle reset request towards the system reset logic.

Reads tagged as instruction fetches return their data without any check. Software sees an 8-bit control/status byte that holds the reset mask and the error flag. Software can write that byte whole, or change one of its two live bits on its own. For test, a dedicated input inverts the parity bit stored by a write, which plants a detectable error. The memory contents are not cleared by reset.

Top module: `parity_ram`

## Requirements
- R1: After reset the control/status byte reads 0x00 (mask 0, flag 0) and `rst_req_o` is low.
- R2: A read issued with `mem_re_i` high returns, on `mem_rdata_o` in the next cycle, the byte last written to that address. A location written without injection never reports an error.
- R3: Parity is even: the stored ninth bit is the XOR of the eight data bits. A data read (`mem_fetch_i` = 0) whose nine stored bits XOR to 1 is an error. A write with `inj_par_flip_i` = 1 stores the inverted parity bit but stores the data bits unchanged.
- R4: A read with `mem_fetch_i` = 1 is never checked. It sets no flag and raises no reset request, even on a corrupted location.
- R5: A parity error sets the error flag (control/status bit 0) on the clock edge after read data becomes valid. This happens whatever the value of the mask.
- R6: When the mask (control/status bit 7) is 0, a parity error drives `rst_req_o` high for exactly one cycle, in the same cycle in which the flag first reads 1.
- R7: When the mask is 1, a parity error leaves `rst_req_o` low.
- R8: Once set, the flag stays 1 through error-free reads. Writing 1 to it has no effect.
- R9: The flag clears when software writes 0 to bit 0. This works through a whole-byte write (`csr_we_i`). It also works through a single-bit write (`csr_bit_we_i` with `csr_bit_sel_i` = 0, value taken from `csr_wdata_i[0]`).
- R10: Bits 6 to 1 of the control/status byte always read 0, whatever was written to them.
- R11: If a hardware error set and a software clear fall on the same clock edge, the flag reads 1 afterwards.
- R12: A single-bit write with `csr_bit_sel_i` = 1 loads the mask from `csr_wdata_i[0]` and leaves the flag unchanged. A whole-byte write loads the mask from bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mem_addr_i | input | ADDR_W | Memory address |
| mem_wdata_i | input | 8 | Write data |
| mem_we_i | input | 1 | Write enable |
| mem_re_i | input | 1 | Read enable |
| mem_fetch_i | input | 1 | 1 = instruction fetch (unchecked), 0 = data read (checked) |
| inj_par_flip_i | input | 1 | Test only: store inverted parity on this write |
| mem_rdata_o | output | 8 | Read data, valid the cycle after a read |
| csr_we_i | input | 1 | Whole-byte control/status write |
| csr_bit_we_i | input | 1 | Single-bit control/status write |
| csr_bit_sel_i | input | 1 | Bit select for single-bit write: 0 flag, 1 mask |
| csr_wdata_i | input | 8 | Control/status write data |
| csr_rdata_o | output | 8 | Control/status read value {mask, 000000, flag} |
| rst_req_o | output | 1 | One-cycle reset request on an unmasked parity error |

## Verification
The bench builds the block with `ADDR_W` = 4, which gives 16 locations. At that size the bench writes and reads back every address with distinct patterns, including bytes of odd and even weight. Injected corruption can then be placed at the lowest and highest addresses. The small depth leaves room in the run for the mask, the sticky flag and clear behaviour, and the edge where a clear and an error meet.

// File: rtl/pram_pkg.sv
package pram_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = BYTE_W + 1;
    localparam int MASK_POS = 7;
    localparam int FLAG_POS = 0;

    typedef struct packed {
        logic              par;
        logic [BYTE_W-1:0] data;
    } pram_word_t;

    typedef enum logic {
        SEL_FLAG = 1'b0,
        SEL_MASK = 1'b1
    } csr_sel_e;

    typedef struct packed {
        logic mask;
        logic flag;
    } csr_state_t;

    function automatic logic even_par(input logic [BYTE_W-1:0] d);
        return ^d;
    endfunction

    function automatic logic word_bad(input pram_word_t w);
        return ^{w.par, w.data};
    endfunction

    function automatic pram_word_t encode(input logic [BYTE_W-1:0] d, input logic flip);
        pram_word_t w;
        w.data = d;
        w.par  = even_par(d) ^ flip;
        return w;
    endfunction

endpackage

// File: rtl/pram_array.sv
module pram_array
    import pram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  pram_word_t        wword_i,
    input  logic              re_i,
    output pram_word_t        rword_o
);
    localparam int DEPTH = 1 << ADDR_W;

    pram_word_t store [DEPTH];
    pram_word_t rword_q;

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            store[addr_i] <= wword_i;
        end
        if (re_i) begin
            rword_q <= store[addr_i];
        end
    end

    assign rword_o = rword_q;

endmodule

// File: rtl/pram_check.sv
module pram_check
    import pram_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       re_i,
    input  logic       fetch_i,
    input  pram_word_t rword_i,
    output logic       err_o
);
    logic valid_q;
    logic fetch_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_q <= 1'b0;
            fetch_q <= 1'b0;
        end else begin
            valid_q <= re_i;
            fetch_q <= fetch_i;
        end
    end

    always_comb begin
        err_o = valid_q && !fetch_q && word_bad(rword_i);
    end

endmodule

// File: rtl/pram_csr.sv
module pram_csr
    import pram_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              byte_we_i,
    input  logic              bit_we_i,
    input  csr_sel_e          bit_sel_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              err_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              rst_req_o
);
    csr_state_t st_q;
    logic       req_q;
    logic       sw_clear;
    logic       mask_load;
    logic       mask_val;

    always_comb begin
        sw_clear  = (byte_we_i && !wdata_i[FLAG_POS]) ||
                    (bit_we_i && bit_sel_i == SEL_FLAG && !wdata_i[0]);
        mask_load = byte_we_i || (bit_we_i && bit_sel_i == SEL_MASK);
        mask_val  = byte_we_i ? wdata_i[MASK_POS] : wdata_i[0];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q  <= '0;
            req_q <= 1'b0;
        end else begin
            if (mask_load) begin
                st_q.mask <= mask_val;
            end
            if (err_i) begin
                st_q.flag <= 1'b1;
            end else if (sw_clear) begin
                st_q.flag <= 1'b0;
            end
            req_q <= err_i && !st_q.mask;
        end
    end

    always_comb begin
        rdata_o           = '0;
        rdata_o[MASK_POS] = st_q.mask;
        rdata_o[FLAG_POS] = st_q.flag;
    end

    assign rst_req_o = req_q;

endmodule

// File: rtl/parity_ram.sv
module parity_ram
    import pram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] mem_addr_i,
    input  logic [7:0]        mem_wdata_i,
    input  logic              mem_we_i,
    input  logic              mem_re_i,
    input  logic              mem_fetch_i,
    input  logic              inj_par_flip_i,
    output logic [7:0]        mem_rdata_o,
    input  logic              csr_we_i,
    input  logic              csr_bit_we_i,
    input  logic              csr_bit_sel_i,
    input  logic [7:0]        csr_wdata_i,
    output logic [7:0]        csr_rdata_o,
    output logic              rst_req_o
);
    pram_word_t wword;
    pram_word_t rword;
    logic       par_err;

    assign wword = encode(mem_wdata_i, inj_par_flip_i);

    pram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk_i   (clk_i),
        .addr_i  (mem_addr_i),
        .we_i    (mem_we_i),
        .wword_i (wword),
        .re_i    (mem_re_i),
        .rword_o (rword)
    );

    pram_check u_check (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .re_i    (mem_re_i),
        .fetch_i (mem_fetch_i),
        .rword_i (rword),
        .err_o   (par_err)
    );

    pram_csr u_csr (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .byte_we_i (csr_we_i),
        .bit_we_i  (csr_bit_we_i),
        .bit_sel_i (csr_sel_e'(csr_bit_sel_i)),
        .wdata_i   (csr_wdata_i),
        .err_i     (par_err),
        .rdata_o   (csr_rdata_o),
        .rst_req_o (rst_req_o)
    );

    assign mem_rdata_o = rword.data;

endmodule

// File: rtl/pram_sva.sv
module pram_sva (
    input logic       clk_i,
    input logic       rst_i,
    input logic       mem_re_i,
    input logic       mem_fetch_i,
    input logic       csr_we_i,
    input logic       csr_bit_we_i,
    input logic       csr_bit_sel_i,
    input logic [7:0] csr_wdata_i,
    input logic [7:0] csr_rdata_o,
    input logic       rst_req_o
);
    logic clr_try;
    assign clr_try = (csr_we_i && !csr_wdata_i[0]) ||
                     (csr_bit_we_i && !csr_bit_sel_i && !csr_wdata_i[0]);

    assert_reserved_zero_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        csr_rdata_o[6:1] == 6'b0);

    assert_req_with_flag_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_req_o |-> csr_rdata_o[0]);

    assert_mask_blocks_req_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_req_o |-> !$past(csr_rdata_o[7]));

    assert_req_needs_data_read_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_req_o |-> $past(mem_re_i && !mem_fetch_i, 2));

    assert_flag_rise_from_read_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(csr_rdata_o[0]) |-> $past(mem_re_i && !mem_fetch_i, 2));

    assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(csr_rdata_o[0]) && !$past(clr_try)) |-> csr_rdata_o[0]);

endmodule

bind parity_ram pram_sva u_sva (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .mem_re_i      (mem_re_i),
    .mem_fetch_i   (mem_fetch_i),
    .csr_we_i      (csr_we_i),
    .csr_bit_we_i  (csr_bit_we_i),
    .csr_bit_sel_i (csr_bit_sel_i),
    .csr_wdata_i   (csr_wdata_i),
    .csr_rdata_o   (csr_rdata_o),
    .rst_req_o     (rst_req_o)
);

// File: tb/sim_parity_ram.sv
`timescale 1ns/1ps
module sim_parity_ram;
    localparam int AW = 4;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_we, mem_re, mem_fetch, inj;
    logic [7:0]    mem_rdata;
    logic          csr_we, csr_bit_we, csr_bit_sel;
    logic [7:0]    csr_wdata;
    logic [7:0]    csr_rdata;
    logic          rst_req;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    logic [7:0] model [N];
    logic [7:0] exp_q [$];

    always #4 clk = ~clk;

    parity_ram #(.ADDR_W(AW)) u0 (
        .clk_i(clk), .rst_i(rst),
        .mem_addr_i(mem_addr), .mem_wdata_i(mem_wdata),
        .mem_we_i(mem_we), .mem_re_i(mem_re), .mem_fetch_i(mem_fetch),
        .inj_par_flip_i(inj), .mem_rdata_o(mem_rdata),
        .csr_we_i(csr_we), .csr_bit_we_i(csr_bit_we), .csr_bit_sel_i(csr_bit_sel),
        .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata), .rst_req_o(rst_req)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        mem_we = 0; mem_re = 0; mem_fetch = 0; inj = 0;
        csr_we = 0; csr_bit_we = 0; csr_bit_sel = 0;
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        idle_all();
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d, input bit flip);
        mem_addr = a; mem_wdata = d; mem_we = 1; inj = flip;
        model[a] = d;
        cycle();
    endtask

    task automatic do_read(input logic [AW-1:0] a, input bit fetch);
        mem_addr = a; mem_re = 1; mem_fetch = fetch;
        exp_q.push_back(model[a]);
        cycle();
    endtask

    task automatic csr_byte(input logic [7:0] v);
        csr_wdata = v; csr_we = 1;
        cycle();
    endtask

    task automatic csr_bit(input bit sel, input bit v);
        csr_wdata = {7'b0, v}; csr_bit_we = 1; csr_bit_sel = sel;
        cycle();
    endtask

    // monitor: compares read data against the scoreboard queue (R2)
    initial begin
        forever begin
            @(posedge clk);
            if (mem_re && !rst) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    chk(0, "R2 unexpected read", {24'b0, mem_rdata}, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(mem_rdata === e, "R2 read data", {24'b0, mem_rdata}, {24'b0, e});
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        finish_run();
    end

    initial begin
        idle_all();
        mem_addr = '0; mem_wdata = '0; csr_wdata = '0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk(csr_rdata === 8'h00, "R1 csr reset", {24'b0, csr_rdata}, 0);
        chk(rst_req === 1'b0, "R1 req reset", {31'b0, rst_req}, 0);

        // R2 R3: fill all locations, odd/even weight patterns, read back clean
        for (int i = 0; i < N; i++) do_write(i[AW-1:0], 8'(i * 37 + 1), 0);
        for (int i = 0; i < N; i++) do_read(i[AW-1:0], 0);
        cycle();
        chk(csr_rdata === 8'h00, "R2 no error on clean reads", {24'b0, csr_rdata}, 0);

        // R4: corrupted location read as fetch
        do_write(0, 8'h5A, 1);
        do_read(0, 1);
        cycle();
        chk(csr_rdata[0] === 1'b0, "R4 fetch unchecked flag", {31'b0, csr_rdata[0]}, 0);
        chk(rst_req === 1'b0, "R4 fetch unchecked req", {31'b0, rst_req}, 0);

        // R3 R5 R6: data read of corrupted location, mask 0
        do_read(0, 0);
        chk(csr_rdata[0] === 1'b0, "R5 flag not yet set", {31'b0, csr_rdata[0]}, 0);
        cycle();
        chk(csr_rdata === 8'h01, "R5 flag set", {24'b0, csr_rdata}, 8'h01);
        chk(rst_req === 1'b1, "R6 req pulse", {31'b0, rst_req}, 1);
        cycle();
        chk(rst_req === 1'b0, "R6 req one cycle", {31'b0, rst_req}, 0);

        // R8: sticky through clean reads, write 1 no effect
        do_read(1, 0);
        cycle();
        csr_byte(8'h01);
        chk(csr_rdata[0] === 1'b1, "R8 flag sticky", {31'b0, csr_rdata[0]}, 1);
        csr_bit(0, 1);
        chk(csr_rdata[0] === 1'b1, "R8 bit write 1 no effect", {31'b0, csr_rdata[0]}, 1);

        // R9: byte clear, R10: reserved bits
        csr_byte(8'h7E);
        chk(csr_rdata === 8'h00, "R9 byte clear R10 reserved", {24'b0, csr_rdata}, 0);

        // R12 R7: mask via bit write, error under mask
        csr_bit(1, 1);
        chk(csr_rdata === 8'h80, "R12 mask bit write", {24'b0, csr_rdata}, 8'h80);
        do_write(N-1, 8'hFF, 1);
        do_read(N-1, 0);
        cycle();
        chk(csr_rdata === 8'h81, "R5 flag under mask", {24'b0, csr_rdata}, 8'h81);
        chk(rst_req === 1'b0, "R7 masked req", {31'b0, rst_req}, 0);
        cycle();
        chk(rst_req === 1'b0, "R7 masked req later", {31'b0, rst_req}, 0);

        // R9: bit clear of flag leaves mask
        csr_bit(0, 0);
        chk(csr_rdata === 8'h80, "R9 bit clear", {24'b0, csr_rdata}, 8'h80);

        // R12: byte write of mask 0 with flag bit 1
        csr_byte(8'h01);
        chk(csr_rdata === 8'h00, "R12 byte mask load", {24'b0, csr_rdata}, 0);

        // R11: error set and software clear on the same edge
        do_read(N-1, 0);
        csr_byte(8'h00);
        chk(csr_rdata[0] === 1'b1, "R11 set wins", {31'b0, csr_rdata[0]}, 1);
        chk(rst_req === 1'b1, "R6 req on second error", {31'b0, rst_req}, 1);
        csr_byte(8'h00);
        chk(csr_rdata === 8'h00, "R9 clear after race", {24'b0, csr_rdata}, 0);

        // R3: rewrite clean restores correct parity
        do_write(N-1, 8'h01, 0);
        do_read(N-1, 0);
        cycle();
        chk(csr_rdata[0] === 1'b0, "R3 rewrite clean", {31'b0, csr_rdata[0]}, 0);
        chk(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);

        cycle();
        finish_run();
    end
endmodule